// File: doc/BRIEF.md
# Boundary Scan Test Port

This block is a serial test port for a chip's boundary. A 16-state controller advances on the rising edge of a test clock, steered by one mode-select input. Depending on the state and on the active instruction, the serial input is routed to the serial output through one of three paths:

- a 2-bit instruction shift register;
- a 1-bit bypass stage;
- a boundary register with one cell per pin.

The boundary register has a parallel hold latch. Under the external-test instruction, that latch drives the pins in place of the core's own values.

A test host walks the controller with mode-select to capture, shift and update either the instruction path or the selected data path. The serial link has no valid/ready handshake and no back-pressure. One bit moves on every rising test-clock edge while the controller is in a shift state. The host stalls a transfer by steering into a pause state, and the contents are held there. The serial output is re-timed to the falling edge. Its enable is a separate output, and it is low outside the two shift states.

Top module: `scan_port`

## Requirements
- R1: Power-on reset (`rst_n` low) puts the controller in its reset state, selects bypass, clears the hold latch to zero and drives `ser_oe` low; `pin_out` then equals `core_in`.
- R2: Five consecutive rising edges with `mode_sel` high reach the reset state from any state, and the reset state forces the bypass instruction.
- R3: In the capture-instruction state the instruction shift register loads binary 01; its bit 0 is shifted out first, so the first two bits seen on `ser_out` are 1 then 0.
- R4: In the shift-instruction state the instruction shift register moves one bit toward `ser_out` on each rising edge, taking `ser_in` at its top, so an input bit appears on `ser_out` two shifts later.
- R5: The active instruction changes only on the falling edge in the update-instruction state, decoding 00 as external test, 01 as sample and 11 as bypass; code 10 selects bypass.
- R6: Under bypass the data path is one bit long and captures 0 in the capture-data state: the first bit out is 0 and each input bit emerges one shift later.
- R7: Under sample or external test, the capture-data state loads `pin_in` into the boundary register, which shifts out from bit 0 upward while `ser_in` enters at the top bit.
- R8: The hold latch takes the boundary register only on the falling edge in the update-data state and keeps its value through every other state, including shifting and pausing.
- R9: Under external test `pin_out` equals the hold latch; under any other instruction `pin_out` equals `core_in`.
- R10: `ser_oe` is high only while the controller is in shift-data or shift-instruction, and both `ser_out` and `ser_oe` change on the falling edge.
- R11: From the second data exit state, `mode_sel` high moves to update-data and low returns to shift-data with the register contents intact.
- R12: From update-data, `mode_sel` high moves to select-data-scan and low moves to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mode_sel | input | 1 | Controller steering input, sampled on rising edge |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, updated on falling edge |
| ser_oe | output | 1 | Drive enable for ser_out (low means high impedance) |
| pin_in | input | BSR_W | Values observed at the boundary pins |
| core_in | input | BSR_W | Functional values the core wants on the pins |
| pin_out | output | BSR_W | Values driven to the boundary pins |

## Verification
A controller that has drifted to the wrong state shows up within one falling edge. Either `ser_oe` rises or falls at the wrong place, or the captured pattern (01, zero, or `pin_in`) appears at the wrong bit position in the serial stream. A wrong instruction decode appears at `pin_out` on the next falling edge after the update-instruction state, because the pins switch between `core_in` and the hold latch. A hold latch that updates outside the update-data state appears at `pin_out` under external test during the same shift or pause that disturbs it. The bench therefore watches the pins across every shifted bit and at the rising edge just before the update.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_SPARE  = 2'b10,
    OP_BYPASS = 2'b11
  } scan_op_e;

  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;
endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       mode_sel,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:    nxt = mode_sel ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = mode_sel ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nxt = mode_sel ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxt = mode_sel ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nxt = mode_sel ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nxt = mode_sel ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxt = mode_sel ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nxt = mode_sel ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxt = mode_sel ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nxt = mode_sel ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nxt = mode_sel ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nxt = mode_sel ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nxt = mode_sel ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxt = mode_sel ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nxt = mode_sel ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nxt = mode_sel ? ST_SEL_DR   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // R2
  tlr_after_five_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(mode_sel,1) && $past(mode_sel,2) && $past(mode_sel,3) &&
     $past(mode_sel,4) && $past(mode_sel,5)) |-> state == ST_RESET);

  // R11
  exit2_route_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_EXIT2_DR) |=> (state == ST_UPD_DR || state == ST_SHIFT_DR));

  // R12
  upd_dr_route_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_DR && !mode_sel) |=> state == ST_IDLE);
endmodule

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
module scan_ir
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       ser_in,
  output logic       ir_tail,
  output scan_op_e   op
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) ir_sh <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
    else if (state == ST_SHIFT_IR) ir_sh <= {ser_in, ir_sh[IR_W-1:1]};
  end

  assign ir_tail = ir_sh[0];

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) op <= OP_BYPASS;
    else if (state == ST_RESET) op <= OP_BYPASS;
    else if (state == ST_UPD_IR) begin
      unique case (ir_sh)
        2'b00:   op <= OP_EXTEST;
        2'b01:   op <= OP_SAMPLE;
        default: op <= OP_BYPASS;
      endcase
    end
  end

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> ir_sh == IR_CAPTURE);

  // R5
  op_stable_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |-> $stable(op));

  // R5
  op_no_spare_chk: assert property (@(posedge tck) disable iff (!rst_n)
    op != OP_SPARE);
endmodule

// File: rtl/scan_dr.sv
`timescale 1ns/1ps
module scan_dr
  import scan_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  scan_op_e         op,
  input  logic             ser_in,
  input  logic [BSR_W-1:0] pin_in,
  output logic             dr_tail,
  output logic [BSR_W-1:0] hold_q
);
  logic             byp;
  logic [BSR_W-1:0] bsr;
  logic             use_byp;

  assign use_byp = (op == OP_BYPASS) || (op == OP_SPARE);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp <= 1'b0;
    else if (use_byp) begin
      if (state == ST_CAP_DR)        byp <= 1'b0;
      else if (state == ST_SHIFT_DR) byp <= ser_in;
    end
  end

  generate
    if (BSR_W > 1) begin : g_multi
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) bsr <= '0;
        else if (!use_byp) begin
          if (state == ST_CAP_DR)        bsr <= pin_in;
          else if (state == ST_SHIFT_DR) bsr <= {ser_in, bsr[BSR_W-1:1]};
        end
      end
    end else begin : g_single
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) bsr <= '0;
        else if (!use_byp) begin
          if (state == ST_CAP_DR)        bsr <= pin_in;
          else if (state == ST_SHIFT_DR) bsr <= ser_in;
        end
      end
    end
  endgenerate

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (state == ST_UPD_DR) hold_q <= bsr;
  end

  assign dr_tail = use_byp ? byp : bsr[0];

  // R6
  byp_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && use_byp) |=> byp == 1'b0);

  // R8
  hold_stable_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_DR) |-> $stable(hold_q));

  // R7
  bsr_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && !use_byp) |=> bsr == $past(pin_in));
endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
  import scan_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe,
  input  logic [BSR_W-1:0] pin_in,
  input  logic [BSR_W-1:0] core_in,
  output logic [BSR_W-1:0] pin_out
);
  tap_state_e       state;
  scan_op_e         op;
  logic             ir_tail;
  logic             dr_tail;
  logic [BSR_W-1:0] hold_q;

  scan_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .mode_sel(mode_sel), .state(state)
  );

  scan_ir u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .ser_in(ser_in),
    .ir_tail(ir_tail), .op(op)
  );

  scan_dr #(.BSR_W(BSR_W)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .op(op), .ser_in(ser_in),
    .pin_in(pin_in), .dr_tail(dr_tail), .hold_q(hold_q)
  );

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else begin
      ser_oe <= (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);
      if (state == ST_SHIFT_IR)      ser_out <= ir_tail;
      else if (state == ST_SHIFT_DR) ser_out <= dr_tail;
    end
  end

  generate
    for (genvar i = 0; i < BSR_W; i++) begin : g_pin
      assign pin_out[i] = (op == OP_EXTEST) ? hold_q[i] : core_in[i];
    end
  endgenerate

  // R10
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ser_oe == (state == ST_SHIFT_DR || state == ST_SHIFT_IR));
endmodule

// File: tb/scan_port_tb.sv
`timescale 1ns/1ps
module scan_port_tb;
  localparam int W = 8;

  logic tck = 1'b0, rst_n = 1'b0, mode_sel = 1'b1, ser_in = 1'b0;
  logic [W-1:0] pin_in = '0, core_in = 8'h96;
  logic ser_out, ser_oe;
  logic [W-1:0] pin_out;

  scan_port #(.BSR_W(W)) u_dut (
    .tck(tck), .rst_n(rst_n), .mode_sel(mode_sel), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .pin_in(pin_in), .core_in(core_in),
    .pin_out(pin_out)
  );

  always #2.5 tck = ~tck;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  logic exp_q[$];
  logic [W-1:0] pins_rise;
  logic oe_rise;
  bit done = 0;

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected bit per enabled serial output
  always begin
    @(negedge tck);
    #2;
    if (rst_n && ser_oe) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected serial bit: actual %b expected none", cur_req, ser_out);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (ser_out !== e) begin
          n_bad++;
          $display("FAIL %s serial bit: actual %b expected %b", cur_req, ser_out, e);
        end
      end
    end
  end

  task automatic step(input logic m, input logic d);
    mode_sel = m;
    ser_in   = d;
    @(posedge tck);
    #1;
    pins_rise = pin_out;
    oe_rise   = ser_oe;
    @(negedge tck);
    #1;
  endtask

  task automatic go_idle();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // driver: pushes the expected serial stream, then walks a data scan
  task automatic dr_scan(input logic [W-1:0] din, input logic [W-1:0] exp,
                         input bit pause, input bit from_sel, input bit chain,
                         input bit watch, input logic [W-1:0] hold);
    for (int i = 0; i < W; i++) exp_q.push_back(exp[i]);
    if (!from_sel) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < W; i++) begin
      if (pause && i == W/2 - 1) begin
        step(1'b1, din[i]);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0); // R11: exit2 low returns to shift
      end else begin
        step(i == W-1, din[i]);
      end
      if (watch) chk("R8", pin_out, hold, "pins held while shifting");
    end
    step(1'b1, 1'b0);
    if (watch) begin
      chk("R8", pins_rise, hold, "pins before update falling edge");
      chk("R8", pin_out, din, "pins after update falling edge");
    end
    step(chain, 1'b0);
    chk(cur_req, W'(exp_q.size()), '0, "expected serial bits left over");
  endtask

  task automatic ir_scan(input int n, input logic [3:0] bits);
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    for (int i = 0; i < n - 2; i++) exp_q.push_back(bits[i]);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R10", W'(oe_rise), '0, "oe before falling edge into shift");
    chk("R10", W'(ser_oe), W'(1), "oe after falling edge in shift");
    for (int i = 0; i < n; i++) step(i == n-1, bits[i]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R10", W'(ser_oe), '0, "oe in idle");
    chk(cur_req, W'(exp_q.size()), '0, "expected serial bits left over");
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    cur_req = "R1";
    chk("R1", W'(ser_oe), '0, "oe in reset");
    chk("R1", pin_out, core_in, "pins in reset");
    @(negedge tck);
    rst_n = 1'b1;
    #1;
    go_idle();
    chk("R1", pin_out, core_in, "pins after reset (bypass)");

    // R6 bypass delay
    cur_req = "R6";
    dr_scan(8'b1011_0110, {7'b011_0110, 1'b0}, 0, 0, 0, 0, '0);

    // R3 R4 R5 load SAMPLE through a 4-bit instruction shift
    cur_req = "R4";
    ir_scan(4, 4'b0111);
    chk("R5", pin_out, core_in, "pins under sample");

    // R7 capture pins
    cur_req = "R7";
    pin_in = 8'hA5;
    dr_scan(8'h3C, 8'hA5, 0, 0, 0, 0, '0);
    chk("R9", pin_out, core_in, "pins still core under sample");

    // R5 R9 external test drives the latch
    cur_req = "R3";
    ir_scan(2, 4'b0000);
    chk("R9", pin_out, 8'h3C, "pins under external test");

    // R8 R11 R12 paused scan, then chained scan from update-data
    cur_req = "R11";
    pin_in = 8'h5A;
    dr_scan(8'hC3, 8'h5A, 1, 0, 1, 1, 8'h3C);
    cur_req = "R12";
    pin_in = 8'h0F;
    dr_scan(8'h81, 8'h0F, 0, 1, 0, 1, 8'hC3);

    // R5 spare code 10 acts as bypass
    cur_req = "R5";
    ir_scan(2, 4'b0010);
    chk("R5", pin_out, core_in, "pins under spare code");
    dr_scan(8'b0100_1101, {7'b100_1101, 1'b0}, 0, 0, 0, 0, '0);

    // R2 five highs from shift-data force bypass
    cur_req = "R2";
    ir_scan(2, 4'b0000);
    chk("R2", pin_out, 8'h81, "pins under external test before reset walk");
    pin_in = 8'h33;
    exp_q.push_back(1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b0);
    chk("R2", pin_out, core_in, "pins after five highs");
    step(1'b0, 1'b0);
    dr_scan(8'b1110_0001, {7'b110_0001, 1'b0}, 0, 0, 0, 0, '0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule